// File: doc/BRIEF.md
# Dedicated-Channel Sample/Convert Controller

This block controls an analog-to-digital converter core that serves one input channel. While enabled and not converting, it keeps the sample switch closed so the channel is always being sampled. A trigger closes the sampling window and starts a conversion. When the conversion is done, the result goes into a single result register and the core goes straight back to sampling with no further command.

The trigger can come from two places. The first is the channel's own trigger. The second is a shared scan trigger, which only counts when the channel is a scan-list member. Two physical inputs can feed the sample switch, and a select bit picks between them. That choice takes effect only while sampling. It never changes the trigger path or the result register.

The converter itself is modelled as a busy period of a fixed number of clock cycles. A data word must be supplied in the last busy cycle. A trigger that arrives during a conversion is dropped and raises an overrun flag. Lowering the enable input opens the sample switch and aborts any conversion in progress.

Top module: `dedicated_adc_ctrl`

## Requirements
- R1: While reset is asserted, every output is low and `result` is zero.
- R2: One cycle after `enable` is seen high in idle, `sample_sw` goes high. It stays high for as long as `enable` is high and no conversion is running.
- R3: The effective trigger is `own_trig` OR (`scan_trig` AND `scan_member`). A `scan_trig` without membership leaves the core sampling.
- R4: An effective trigger seen while sampling gives, in the next cycle, `sample_sw` low, `busy` high and `conv_start` high. `conv_start` stays high for that one cycle only.
- R5: `busy` stays high for exactly CONV_CYCLES cycles. In the cycle where it falls, `sample_sw` is high again.
- R6: `result` takes the `conv_data` value present in the last busy cycle. `result_valid` pulses high for one cycle, in the first sampling cycle after completion.
- R7: An effective trigger during `busy` neither restarts nor lengthens the conversion. It sets `overrun`, which stays set until `enable` is low.
- R8: With `enable` low, from the next cycle `sample_sw`, `busy` and `overrun` are low. A conversion in progress yields no `result_valid`, `result` keeps its old value, and triggers are ignored.
- R9: While sampling, `input_sel` (0 = primary input, 1 = alternate input) follows `alt_sel` with one cycle of delay. It holds its value for the whole of a conversion.
- R10: A conversion taken with the alternate input selected delivers its word on the same `result` port, with the same timing as a primary conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Core enable |
| alt_sel | input | 1 | Requested physical input, 0 primary / 1 alternate |
| own_trig | input | 1 | Channel's own trigger |
| scan_trig | input | 1 | Shared scan trigger |
| scan_member | input | 1 | Channel is in the scan list |
| conv_data | input | DATA_W | Converter output word, valid in the last busy cycle |
| sample_sw | output | 1 | Sample switch closed |
| input_sel | output | 1 | Physical input connected to the sample switch |
| conv_start | output | 1 | One-cycle pulse at conversion start |
| busy | output | 1 | Conversion in progress |
| result | output | DATA_W | Result register |
| result_valid | output | 1 | One-cycle pulse when `result` is loaded |
| overrun | output | 1 | Trigger arrived during a conversion |

## Verification
Conversions are started once by the channel's own trigger and once by the scan trigger with membership set. A scan trigger without membership is also applied, which separates correct gating of the scan path from a plain OR of both triggers. A second trigger is injected in the middle of a busy period, which tells an ignored trigger from one that restarts or lengthens the conversion. The alternate-select bit is flipped in the middle of a conversion, and `enable` is dropped during another. These two cases separate input changes that are correctly held or aborted from changes that leak into the sampling path or the result register.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } dadc_state_e;
endpackage

// File: rtl/dadc_trig_merge.sv
module dadc_trig_merge (
  input  logic own_trig,
  input  logic scan_trig,
  input  logic scan_member,
  output logic fire
);
  logic scan_gated;

  always_comb begin
    scan_gated = scan_trig & scan_member;
    fire       = own_trig | scan_gated;
  end
endmodule

// File: rtl/dadc_conv_timer.sv
module dadc_conv_timer #(
  parameter int CONV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

  generate
    if (CONV_CYCLES <= 1) begin : g_single
      always_comb done = run;
    end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (load)
          cnt_d = LAST;
        else if (run && (cnt_q != '0))
          cnt_d = cnt_q - 1'b1;
        done = run && (cnt_q == '0);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt_q <= '0;
        else
          cnt_q <= cnt_d;
      end
    end
  endgenerate
endmodule

// File: rtl/dadc_result_reg.sv
module dadc_result_reg #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture)
        dout <= din;
    end
  end
endmodule

// File: rtl/dedicated_adc_ctrl.sv
module dedicated_adc_ctrl
  import dadc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              alt_sel,
  input  logic              own_trig,
  input  logic              scan_trig,
  input  logic              scan_member,
  input  logic [DATA_W-1:0] conv_data,
  output logic              sample_sw,
  output logic              input_sel,
  output logic              conv_start,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              overrun
);
  dadc_state_e state_q, state_d;
  logic fire;
  logic done;
  logic start_d, start_q;
  logic ovr_d, ovr_q;
  logic sel_d, sel_q;
  logic capture;
  logic timer_run;

  dadc_trig_merge u_trig (
    .own_trig    (own_trig),
    .scan_trig   (scan_trig),
    .scan_member (scan_member),
    .fire        (fire)
  );

  dadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_d),
    .run   (timer_run),
    .done  (done)
  );

  dadc_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .din     (conv_data),
    .dout    (result),
    .valid   (result_valid)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (enable) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (!enable) begin
          state_d = ST_IDLE;
        end else if (fire) begin
          state_d = ST_CONVERT;
          start_d = 1'b1;
        end
      end
      ST_CONVERT: begin
        if (!enable)   state_d = ST_IDLE;
        else if (done) state_d = ST_SAMPLE;
      end
      default: state_d = ST_IDLE;
    endcase

    timer_run = (state_q == ST_CONVERT) && enable;
    capture   = timer_run && done;

    ovr_d = ovr_q;
    if (!enable)
      ovr_d = 1'b0;
    else if ((state_q == ST_CONVERT) && fire)
      ovr_d = 1'b1;

    sel_d = sel_q;
    if (state_q == ST_SAMPLE)
      sel_d = alt_sel;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      ovr_q   <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      ovr_q   <= ovr_d;
      sel_q   <= sel_d;
    end
  end

  always_comb begin
    sample_sw  = (state_q == ST_SAMPLE);
    busy       = (state_q == ST_CONVERT);
    conv_start = start_q;
    overrun    = ovr_q;
    input_sel  = sel_q;
  end
endmodule

// File: rtl/dadc_ctrl_chk.sv
module dadc_ctrl_chk #(
  parameter int CONV_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic own_trig,
  input logic scan_trig,
  input logic scan_member,
  input logic sample_sw,
  input logic input_sel,
  input logic conv_start,
  input logic busy,
  input logic result_valid,
  input logic overrun
);
  logic        trig_seen;
  logic [31:0] busy_run;

  always_comb trig_seen = own_trig || (scan_trig && scan_member);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_run <= '0;
    else if (busy)
      busy_run <= busy_run + 1'b1;
    else
      busy_run <= '0;
  end

  // R2
  sample_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !busy) |=> (sample_sw || busy || !enable));

  // R4
  trig_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_sw && enable && trig_seen) |=> (busy && conv_start && !sample_sw));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 32'(CONV_CYCLES)));

  // R5
  auto_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && (busy_run == 32'(CONV_CYCLES - 1))) |=> (sample_sw && result_valid));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && trig_seen) |=> overrun);

  // R8
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sample_sw && !busy && !overrun));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(input_sel)));

  // R5
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_sw && busy));
endmodule

bind dedicated_adc_ctrl dadc_ctrl_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .own_trig     (own_trig),
  .scan_trig    (scan_trig),
  .scan_member  (scan_member),
  .sample_sw    (sample_sw),
  .input_sel    (input_sel),
  .conv_start   (conv_start),
  .busy         (busy),
  .result_valid (result_valid),
  .overrun      (overrun)
);

// File: tb/dedicated_adc_ctrl_test.sv
module dedicated_adc_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 12;
  localparam int CONV = 8;

  logic clk = 1'b0;
  logic rst_n, enable, alt_sel, own_trig, scan_trig, scan_member;
  logic [DW-1:0] conv_data;
  logic sample_sw, input_sel, conv_start, busy, result_valid, overrun;
  logic [DW-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dedicated_adc_ctrl #(.DATA_W(DW), .CONV_CYCLES(CONV)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .alt_sel(alt_sel),
    .own_trig(own_trig), .scan_trig(scan_trig), .scan_member(scan_member),
    .conv_data(conv_data), .sample_sw(sample_sw), .input_sel(input_sel),
    .conv_start(conv_start), .busy(busy), .result(result),
    .result_valid(result_valid), .overrun(overrun)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && result_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check_eq("R6/R8 unexpected result_valid", 1, 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check_eq("R6 result word", int'(result), int'(e));
      end
    end
  end

  task automatic run_conv(input bit via_scan, input logic [DW-1:0] data,
                          input int extra_at, input int flip_at);
    int  nbusy;
    logic sel0;
    conv_data = data;
    if (via_scan) begin scan_trig = 1'b1; scan_member = 1'b1; end
    else own_trig = 1'b1;
    exp_q.push_back(data);
    tick();
    own_trig = 1'b0; scan_trig = 1'b0;
    check_eq("R4 busy after trigger", int'(busy), 1);
    check_eq("R4 sample_sw off", int'(sample_sw), 0);
    check_eq("R4 conv_start", int'(conv_start), 1);
    sel0  = input_sel;
    nbusy = 1;
    for (int i = 1; i < CONV + 3; i++) begin
      if (i == extra_at) own_trig = 1'b1;
      if (i == flip_at)  alt_sel = ~alt_sel;
      tick();
      own_trig = 1'b0;
      if (i == 1) check_eq("R4 conv_start one cycle", int'(conv_start), 0);
      if (busy) begin
        nbusy++;
        if (input_sel !== sel0) check_eq("R9 input_sel held", int'(input_sel), int'(sel0));
      end else begin
        break;
      end
    end
    check_eq("R5 busy length", nbusy, CONV);
    check_eq("R5 back to sampling", int'(sample_sw), 1);
    check_eq("R6 result_valid at completion", int'(result_valid), 1);
    tick();
    check_eq("R6 result_valid one cycle", int'(result_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check_eq("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; alt_sel = 1'b0; own_trig = 1'b0;
    scan_trig = 1'b0; scan_member = 1'b0; conv_data = '0;
    tick(); tick();
    // R1
    check_eq("R1 sample_sw reset", int'(sample_sw), 0);
    check_eq("R1 busy reset", int'(busy), 0);
    check_eq("R1 conv_start reset", int'(conv_start), 0);
    check_eq("R1 result reset", int'(result), 0);
    check_eq("R1 overrun reset", int'(overrun), 0);
    check_eq("R1 input_sel reset", int'(input_sel), 0);
    rst_n = 1'b1;
    tick(); tick();
    check_eq("R8 idle while disabled", int'(sample_sw), 0);

    enable = 1'b1;
    tick();
    check_eq("R2 sampling after enable", int'(sample_sw), 1);
    tick(); tick();
    check_eq("R2 sampling held", int'(sample_sw), 1);

    run_conv(1'b0, 12'hA5, -1, -1);
    check_eq("R7 no overrun yet", int'(overrun), 0);

    // R3: scan trigger without membership
    scan_member = 1'b0; scan_trig = 1'b1;
    tick();
    scan_trig = 1'b0;
    check_eq("R3 gated scan ignored busy", int'(busy), 0);
    check_eq("R3 gated scan still sampling", int'(sample_sw), 1);
    tick();

    run_conv(1'b1, 12'h3C7, -1, -1);
    scan_member = 1'b0;

    // R7: trigger during conversion
    run_conv(1'b0, 12'h801, 3, -1);
    check_eq("R7 overrun set", int'(overrun), 1);
    tick(); tick();
    check_eq("R7 overrun sticky", int'(overrun), 1);

    // R9 / R10: alternate input
    alt_sel = 1'b1;
    tick();
    check_eq("R9 input_sel follows", int'(input_sel), 1);
    run_conv(1'b0, 12'h5E1, -1, 3);
    check_eq("R9 new select after conversion", int'(input_sel), 0);
    check_eq("R10 alternate result on result port", int'(result), 12'h5E1);

    // R8: disable mid conversion
    conv_data = 12'h0FF;
    own_trig = 1'b1;
    tick();
    own_trig = 1'b0;
    tick(); tick();
    enable = 1'b0;
    tick();
    check_eq("R8 busy dropped", int'(busy), 0);
    check_eq("R8 switch open", int'(sample_sw), 0);
    check_eq("R8 overrun cleared", int'(overrun), 0);
    own_trig = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check_eq("R8 trigger ignored while disabled", int'(busy), 0);
    end
    own_trig = 1'b0;
    for (int i = 0; i < CONV + 2; i++) tick();
    check_eq("R8 result kept", int'(result), 12'h5E1);

    enable = 1'b1;
    tick();
    check_eq("R2 sampling after re-enable", int'(sample_sw), 1);
    run_conv(1'b0, 12'hC3A, -1, -1);
    tick();
    check_eq("R6 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule